// File: doc/BRIEF.md
# Trace Recording Freeze Controller

This block sits beside a control-transfer trace recorder and decides, each cycle, whether a candidate record may be written. It keeps one status bit, `frozen`. While that bit is set, every candidate is dropped. Hardware sets the bit when a selected trap is taken. Software can read the bit, set it or clear it through a one-bit write port.

Two kinds of trap can freeze the recorder: a breakpoint exception and the local counter-overflow interrupt. Each kind has its own enable. The enables come from the supervisor-level control register for traps that target machine or supervisor mode, and from the virtual-supervisor-level control register for traps that target virtual-supervisor mode. The trap that causes the freeze is itself kept out of the record. The bit then stays set until software clears it.

Top module: `brtrc_freeze_ctl`

## Requirements
- R1: After reset `frozen` is 0, and `rec_en` equals `cand_valid` when no trap is present.
- R2: While `frozen` is 1, `rec_en` is 0 whatever the other inputs are.
- R3: A trap with `trap_valid`=1, `trap_irq`=1 and `trap_cause`=13 (the local counter-overflow interrupt) sets `frozen` at the next clock edge when its target is machine (`trap_tgt`=2'b11) or supervisor (`trap_tgt`=2'b01) and `s_ovf_frz`=1.
- R4: A trap with `trap_valid`=1, `trap_irq`=0 and `trap_cause`=3 (breakpoint exception) sets `frozen` at the next clock edge when its target is machine or supervisor and `s_bp_frz`=1.
- R5: For a trap that targets virtual-supervisor mode (`trap_tgt`=2'b10), the freeze decision uses `vs_bp_frz` and `vs_ovf_frz` and ignores `s_bp_frz` and `s_ovf_frz`.
- R6: In the cycle of a trap that sets `frozen`, `rec_en` is 0, so the freezing trap is not recorded.
- R7: Nothing else sets `frozen`: not an overflow cause that is present without `trap_valid` (an interrupt that is pending but not taken), not exception code 13, not interrupt code 3, not a disabled enable, and not target code 2'b00.
- R8: `frozen` holds its value until software changes it. With `sw_wr`=1, the value of `sw_frozen` is loaded at the next clock edge, which can set the bit or clear it.
- R9: When a hardware set and a software write fall in the same cycle, `frozen` becomes 1.
- R10: A trap that does not freeze passes its candidate through: `rec_en` equals `cand_valid` while `frozen` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_irq | input | 1 | 1 for an interrupt, 0 for an exception |
| trap_cause | input | CAUSE_W | Interrupt or exception code |
| trap_tgt | input | 2 | Target mode: 11 machine, 01 supervisor, 10 virtual supervisor, 00 none |
| s_bp_frz | input | 1 | Supervisor-level freeze enable for breakpoints |
| s_ovf_frz | input | 1 | Supervisor-level freeze enable for counter overflow |
| vs_bp_frz | input | 1 | Virtual-supervisor freeze enable for breakpoints |
| vs_ovf_frz | input | 1 | Virtual-supervisor freeze enable for counter overflow |
| cand_valid | input | 1 | A transfer is offered for recording |
| sw_wr | input | 1 | Software write strobe for the freeze bit |
| sw_frozen | input | 1 | Value written by software |
| rec_en | output | 1 | The candidate may be recorded |
| frozen | output | 1 | Current freeze status |

## Verification
A software write and a hardware-triggered freeze can land in the same cycle. The bench provokes this directly by clearing the bit through the write port in the cycle of a freezing overflow trap, and checks that `frozen` reads 1 on the following cycle. A second collision is a freezing trap together with a candidate strobe. Here `rec_en` must be 0 in that cycle even though `frozen` is still 0. A randomized phase hits both collisions again, and a behavioural model judges every cycle.

// File: rtl/brtrc_freeze_ctl.sv
module brtrc_freeze_ctl #(
  parameter int CAUSE_W    = 6,
  parameter int BKPT_CAUSE = 3,
  parameter int OVF_IRQ    = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_valid,
  input  logic               trap_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [1:0]         trap_tgt,
  input  logic               s_bp_frz,
  input  logic               s_ovf_frz,
  input  logic               vs_bp_frz,
  input  logic               vs_ovf_frz,
  input  logic               cand_valid,
  input  logic               sw_wr,
  input  logic               sw_frozen,
  output logic               rec_en,
  output logic               frozen
);
  localparam logic [CAUSE_W-1:0] BKPT_C = CAUSE_W'(BKPT_CAUSE);
  localparam logic [CAUSE_W-1:0] OVF_C  = CAUSE_W'(OVF_IRQ);
  localparam logic [1:0] TGT_M  = 2'b11;
  localparam logic [1:0] TGT_S  = 2'b01;
  localparam logic [1:0] TGT_VS = 2'b10;

  logic to_vs, to_ms, bp_en, ovf_en, is_bp, is_ovf, hw_set;

  assign to_vs  = (trap_tgt == TGT_VS);
  assign to_ms  = (trap_tgt == TGT_M) || (trap_tgt == TGT_S);
  assign bp_en  = to_vs ? vs_bp_frz  : s_bp_frz;
  assign ovf_en = to_vs ? vs_ovf_frz : s_ovf_frz;
  assign is_bp  = !trap_irq && (trap_cause == BKPT_C);
  assign is_ovf =  trap_irq && (trap_cause == OVF_C);
  assign hw_set = trap_valid && (to_vs || to_ms) &&
                  ((is_bp && bp_en) || (is_ovf && ovf_en));

  always_ff @(posedge clk) begin
    if (!rst_n)      frozen <= 1'b0;
    else if (hw_set) frozen <= 1'b1;
    else if (sw_wr)  frozen <= sw_frozen;
  end

  assign rec_en = cand_valid && !frozen && !hw_set;
endmodule

// File: rtl/brtrc_freeze_chk.sv
module brtrc_freeze_chk #(
  parameter int CAUSE_W    = 6,
  parameter int BKPT_CAUSE = 3,
  parameter int OVF_IRQ    = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trap_valid,
  input logic               trap_irq,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic [1:0]         trap_tgt,
  input logic               s_bp_frz,
  input logic               s_ovf_frz,
  input logic               vs_bp_frz,
  input logic               vs_ovf_frz,
  input logic               cand_valid,
  input logic               sw_wr,
  input logic               sw_frozen,
  input logic               rec_en,
  input logic               frozen
);
  logic ms_tgt, vs_tgt, ovf_trap, bp_trap;
  assign ms_tgt   = trap_valid && (trap_tgt == 2'b11 || trap_tgt == 2'b01);
  assign vs_tgt   = trap_valid && (trap_tgt == 2'b10);
  assign ovf_trap = trap_irq && (int'(trap_cause) == OVF_IRQ);
  assign bp_trap  = !trap_irq && (int'(trap_cause) == BKPT_CAUSE);

  assert_frozen_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !rec_en);
  assert_ovf_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_tgt && ovf_trap && s_ovf_frz) |=> frozen);
  assert_bp_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_tgt && bp_trap && s_bp_frz) |=> frozen);
  assert_vs_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_tgt && ((ovf_trap && vs_ovf_frz) || (bp_trap && vs_bp_frz))) |=> frozen);
  assert_trap_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ms_tgt && ((ovf_trap && s_ovf_frz) || (bp_trap && s_bp_frz))) ||
     (vs_tgt && ((ovf_trap && vs_ovf_frz) || (bp_trap && vs_bp_frz)))) |-> !rec_en);
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && !trap_valid && !sw_wr) |=> !frozen);
  assert_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !sw_wr) |=> frozen);
endmodule

bind brtrc_freeze_ctl brtrc_freeze_chk #(
  .CAUSE_W(CAUSE_W), .BKPT_CAUSE(BKPT_CAUSE), .OVF_IRQ(OVF_IRQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_irq(trap_irq),
  .trap_cause(trap_cause), .trap_tgt(trap_tgt), .s_bp_frz(s_bp_frz),
  .s_ovf_frz(s_ovf_frz), .vs_bp_frz(vs_bp_frz), .vs_ovf_frz(vs_ovf_frz),
  .cand_valid(cand_valid), .sw_wr(sw_wr), .sw_frozen(sw_frozen),
  .rec_en(rec_en), .frozen(frozen)
);

// File: tb/tb_brtrc_freeze_ctl.sv
module tb_brtrc_freeze_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_valid = 0, trap_irq = 0;
  logic [5:0] trap_cause = '0;
  logic [1:0] trap_tgt = '0;
  logic s_bp_frz = 0, s_ovf_frz = 0, vs_bp_frz = 0, vs_ovf_frz = 0;
  logic cand_valid = 0, sw_wr = 0, sw_frozen = 0;
  logic rec_en, frozen;

  int checks = 0;
  int errors = 0;
  bit model_fz = 1'b0;

  always #2 clk = ~clk;

  brtrc_freeze_ctl dut (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_irq(trap_irq),
    .trap_cause(trap_cause), .trap_tgt(trap_tgt), .s_bp_frz(s_bp_frz),
    .s_ovf_frz(s_ovf_frz), .vs_bp_frz(vs_bp_frz), .vs_ovf_frz(vs_ovf_frz),
    .cand_valid(cand_valid), .sw_wr(sw_wr), .sw_frozen(sw_frozen),
    .rec_en(rec_en), .frozen(frozen)
  );

  function automatic bit freeze_now();
    bit enb, eno;
    if (!trap_valid || trap_tgt == 2'b00) return 1'b0;
    enb = (trap_tgt == 2'b10) ? vs_bp_frz : s_bp_frz;
    eno = (trap_tgt == 2'b10) ? vs_ovf_frz : s_ovf_frz;
    if (trap_irq && trap_cause == 6'd13 && eno) return 1'b1;
    if (!trap_irq && trap_cause == 6'd3 && enb) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic tv, input logic irq, input int cause, input logic [1:0] tgt,
                     input logic sb, input logic so, input logic vb, input logic vo,
                     input logic cand, input logic swr, input logic swv, input string tag);
    bit fz;
    @(negedge clk);
    trap_valid = tv; trap_irq = irq; trap_cause = 6'(cause); trap_tgt = tgt;
    s_bp_frz = sb; s_ovf_frz = so; vs_bp_frz = vb; vs_ovf_frz = vo;
    cand_valid = cand; sw_wr = swr; sw_frozen = swv;
    #1;
    fz = freeze_now();
    check(tag, "frozen", frozen, model_fz);
    check(tag, "rec_en", rec_en, cand && !model_fz && !fz);
    @(posedge clk);
    if (fz) model_fz = 1'b1;
    else if (swr) model_fz = swv;
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 2'b00, 0, 0, 0, 0, 1, 0, 0, tag);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle("R1");
    idle("R1");
    // breakpoint to supervisor, freeze enabled
    cyc(1, 0, 3, 2'b01, 1, 0, 0, 0, 1, 0, 0, "R6");
    idle("R4");
    idle("R2");
    idle("R8");
    cyc(0, 0, 0, 2'b00, 0, 0, 0, 0, 1, 1, 0, "R8");
    idle("R8");
    // overflow interrupt to machine
    cyc(1, 1, 13, 2'b11, 0, 1, 0, 0, 1, 0, 0, "R3");
    idle("R3");
    cyc(0, 0, 0, 2'b00, 0, 0, 0, 0, 0, 1, 0, "R8");
    // hardware set collides with software clear
    cyc(1, 1, 13, 2'b01, 0, 1, 0, 0, 1, 1, 0, "R9");
    idle("R9");
    cyc(0, 0, 0, 2'b00, 0, 0, 0, 0, 0, 1, 0, "R8");
    // virtual-supervisor uses its own enables
    cyc(1, 0, 3, 2'b10, 1, 1, 0, 0, 1, 0, 0, "R5");
    idle("R5");
    cyc(1, 1, 13, 2'b10, 0, 0, 0, 1, 1, 0, 0, "R5");
    idle("R5");
    cyc(0, 0, 0, 2'b00, 0, 0, 0, 0, 0, 1, 0, "R8");
    // non-freezing events
    cyc(0, 1, 13, 2'b11, 1, 1, 1, 1, 1, 0, 0, "R7");
    cyc(1, 0, 13, 2'b11, 1, 1, 1, 1, 1, 0, 0, "R7");
    cyc(1, 1, 3, 2'b01, 1, 1, 1, 1, 1, 0, 0, "R7");
    cyc(1, 1, 13, 2'b00, 1, 1, 1, 1, 1, 0, 0, "R7");
    cyc(1, 1, 13, 2'b11, 1, 0, 1, 1, 1, 0, 0, "R7");
    cyc(1, 0, 7, 2'b01, 1, 1, 1, 1, 1, 0, 0, "R10");
    idle("R7");
    // software set
    cyc(0, 0, 0, 2'b00, 0, 0, 0, 0, 1, 1, 1, "R8");
    idle("R8");
    idle("R2");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int c;
      c = ($urandom % 2 == 0) ? (($urandom % 2 == 0) ? 13 : 3) : int'($urandom % 64);
      cyc(1'($urandom % 2), 1'($urandom % 2), c, 2'($urandom % 4),
          1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
          1'($urandom % 2), 1'(($urandom % 5) == 0), 1'($urandom % 2), "R2");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule